// File: doc/BRIEF.md
# Multiprocessor Address-Wakeup UART Receiver

This block receives asynchronous serial frames in which a ninth bit tags the byte as an address (1) or as data (0). Several receivers can share one line. Each listener sets its wake-up enable bit and then sleeps through data meant for other nodes. It wakes by itself on the next address frame and then receives normally until software arms wake-up again.

While wake-up is armed, a completed data-tagged frame is dropped inside the receiver. It does not reach the data register, it raises no flag and it requests no interrupt. An address-tagged frame sets the address status bit and clears the wake-up enable in hardware. That frame is then processed as an ordinary reception. Line sampling uses an external 16x oversampling enable; the receiver has no baud generator of its own.

Top module: `mp_wake_rx`

## Requirements
- R1: After synchronous reset, wake-up enable, full flag, framing-error flag, overrun flag, address status bit, data register and both interrupt outputs are all 0.
- R2: A frame is one low start bit, 8 data bits sent LSB first, the address-tag bit and one stop bit. Each bit lasts 16 oversampling ticks and is sampled at its middle. A start is confirmed only if the line is still low 8 ticks after the first low sample, so a low pulse shorter than half a bit produces no frame.
- R3: With wake-up enable 0, a frame with stop bit 1 that arrives while no flag is set is loaded into the data register and sets the full flag. The address status bit takes the received tag value.
- R4: With wake-up enable 1, a frame with tag 0 leaves the data register, the address status bit and all three flags unchanged, and so raises no new interrupt request.
- R5: With wake-up enable 1, a frame with tag 1 sets the address status bit to 1 and clears wake-up enable. The frame itself is then loaded and flagged as in R3, R6 and R7.
- R6: A stop bit sampled as 0 on a frame that is not skipped sets the framing-error flag and does not load the data. A skipped frame with a bad stop bit sets no flag.
- R7: A frame that completes while the full flag is 1 sets the overrun flag and the data register keeps its old value.
- R8: While the framing-error or overrun flag is 1, completed frames load nothing and set no flag until both flags are cleared.
- R9: A one-cycle pulse on a clear input resets the matching flag (full, framing error, overrun) to 0.
- R10: The receive interrupt output equals full AND receive-interrupt enable. The error interrupt output equals (framing error OR overrun) AND error-interrupt enable.
- R11: The line sampler advances only on cycles with the oversampling enable high. A frame sent while the enable is held low produces nothing.
- R12: A write pulse loads wake-up enable from the write data bit, so software can both arm and disarm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| os_tick_i | input | 1 | 16x oversampling enable, one cycle per tick |
| wake_wr_i | input | 1 | Write strobe for the wake-up enable bit |
| wake_wdata_i | input | 1 | Value written to wake-up enable |
| clr_full_i | input | 1 | Clear pulse for the full flag |
| clr_ferr_i | input | 1 | Clear pulse for the framing-error flag |
| clr_ovr_i | input | 1 | Clear pulse for the overrun flag |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| rx_data_o | output | 8 | Receive data register |
| rx_full_o | output | 1 | Full flag |
| ferr_o | output | 1 | Framing-error flag |
| ovr_o | output | 1 | Overrun flag |
| addr_flag_o | output | 1 | Last accepted address-tag bit |
| wake_en_o | output | 1 | Wake-up enable state |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A mixed stream is sent with wake-up armed: data frames, a bad-stop data frame, then an address frame and later data. This separates frames that must be skipped from those that must load. It also shows that the enable clears on the address frame and not before. Back-to-back frames without clearing tell the overrun path apart from a load. A frame sent while an error flag is still set tells blocking apart from overrun. A short low glitch and a frame sent with the oversampling enable held low must both leave every flag at 0. Software arm and disarm writes show that the write path controls the bit alongside the hardware clear.

// File: rtl/mpr_pkg.sv
`timescale 1ns/1ps
package mpr_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned OVS     = 16;
    localparam int unsigned OVS_W   = $clog2(OVS);
    localparam int unsigned BIT_CNT = DATA_W + 2;   // data, tag, stop
    localparam int unsigned IDX_W   = $clog2(BIT_CNT);
    localparam int unsigned SYNC_N  = 2;

    typedef enum logic [1:0] {
        SMP_IDLE,
        SMP_START,
        SMP_BITS
    } smp_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              addr;
        logic              stop_ok;
    } rx_frame_t;

    typedef struct packed {
        logic full;
        logic frame_err;
        logic overrun;
    } rx_flags_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SKIP,
        ACT_HOLD,
        ACT_OVR,
        ACT_FERR,
        ACT_LOAD
    } rx_act_e;

    function automatic logic at_mid(input logic [OVS_W-1:0] c);
        return c == OVS_W'(OVS/2 - 1);
    endfunction

    function automatic logic at_end(input logic [OVS_W-1:0] c);
        return c == OVS_W'(OVS - 1);
    endfunction

    function automatic rx_frame_t frame_from_bits(input logic [BIT_CNT-1:0] b);
        rx_frame_t f;
        f.data    = b[DATA_W-1:0];
        f.addr    = b[DATA_W];
        f.stop_ok = b[DATA_W+1];
        return f;
    endfunction

    // Outcome of one completed frame, in priority order.
    function automatic rx_act_e classify(input logic vld, input logic wake,
                                         input rx_frame_t f, input rx_flags_t fl);
        if (!vld)                        return ACT_NONE;
        if (wake && !f.addr)             return ACT_SKIP;
        if (fl.frame_err || fl.overrun)  return ACT_HOLD;
        if (fl.full)                     return ACT_OVR;
        if (!f.stop_ok)                  return ACT_FERR;
        return ACT_LOAD;
    endfunction
endpackage

// File: rtl/mpr_sync.sv
`timescale 1ns/1ps
module mpr_sync
    import mpr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [SYNC_N-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '1;
        else     stage_q <= {stage_q[SYNC_N-2:0], d_i};
    end

    assign q_o = stage_q[SYNC_N-1];
endmodule

// File: rtl/mpr_sampler.sv
`timescale 1ns/1ps
module mpr_sampler
    import mpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      rx_i,
    output logic      frame_vld_o,
    output rx_frame_t frame_o
);
    smp_state_e         state_q;
    logic [OVS_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [BIT_CNT-1:0] shift_q;
    logic [BIT_CNT-1:0] shift_nxt;
    logic               vld_q;
    rx_frame_t          frame_q;

    assign shift_nxt = {rx_i, shift_q[BIT_CNT-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SMP_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            vld_q   <= 1'b0;
            frame_q <= '0;
        end else begin
            vld_q <= 1'b0;
            if (tick_i) begin
                unique case (state_q)
                    SMP_IDLE: begin
                        if (!rx_i) begin
                            state_q <= SMP_START;
                            cnt_q   <= '0;
                        end
                    end
                    SMP_START: begin
                        if (at_mid(cnt_q)) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= rx_i ? SMP_IDLE : SMP_BITS;
                        end else begin
                            cnt_q <= cnt_q + OVS_W'(1);
                        end
                    end
                    SMP_BITS: begin
                        if (at_end(cnt_q)) begin
                            cnt_q   <= '0;
                            shift_q <= shift_nxt;
                            if (idx_q == IDX_W'(BIT_CNT - 1)) begin
                                vld_q   <= 1'b1;
                                frame_q <= frame_from_bits(shift_nxt);
                                state_q <= SMP_IDLE;
                            end else begin
                                idx_q <= idx_q + IDX_W'(1);
                            end
                        end else begin
                            cnt_q <= cnt_q + OVS_W'(1);
                        end
                    end
                    default: state_q <= SMP_IDLE;
                endcase
            end
        end
    end

    assign frame_vld_o = vld_q;
    assign frame_o     = frame_q;

    // R2: a completed frame is reported for a single cycle
    assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);
    // R11: without an oversampling tick the sampler holds its position
    assert_tick_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(state_q) && $stable(cnt_q) && $stable(idx_q)));
endmodule

// File: rtl/mpr_status.sv
`timescale 1ns/1ps
module mpr_status
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld_i,
    input  rx_frame_t         frame_i,
    input  logic              wake_wr_i,
    input  logic              wake_wdata_i,
    input  logic              clr_full_i,
    input  logic              clr_ferr_i,
    input  logic              clr_ovr_i,
    output logic [DATA_W-1:0] data_o,
    output rx_flags_t         flags_o,
    output logic              addr_o,
    output logic              wake_o
);
    logic [DATA_W-1:0] data_q;
    rx_flags_t         flags_q;
    logic              addr_q;
    logic              wake_q;
    rx_act_e           act;

    always_comb act = classify(frame_vld_i, wake_q, frame_i, flags_q);

    // Frame outcomes are applied after software writes, so a set wins
    // over a clear in the same cycle and the hardware wake clear wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            flags_q <= '0;
            addr_q  <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            if (wake_wr_i)  wake_q            <= wake_wdata_i;
            if (clr_full_i) flags_q.full      <= 1'b0;
            if (clr_ferr_i) flags_q.frame_err <= 1'b0;
            if (clr_ovr_i)  flags_q.overrun   <= 1'b0;
            if (act != ACT_NONE && act != ACT_SKIP) begin
                addr_q <= frame_i.addr;
                if (wake_q) wake_q <= 1'b0;
            end
            unique case (act)
                ACT_OVR:  flags_q.overrun   <= 1'b1;
                ACT_FERR: flags_q.frame_err <= 1'b1;
                ACT_LOAD: begin
                    data_q       <= frame_i.data;
                    flags_q.full <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign data_o  = data_q;
    assign flags_o = flags_q;
    assign addr_o  = addr_q;
    assign wake_o  = wake_q;

    // R4: a skipped frame leaves data and status untouched
    assert_skip_data_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && wake_q && !frame_i.addr) |=> ($stable(data_q) && $stable(addr_q)));
    assert_skip_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && wake_q && !frame_i.addr && !clr_full_i && !clr_ferr_i && !clr_ovr_i)
        |=> $stable(flags_q));
    // R5: an address frame ends the wake-up wait and sets the status bit
    assert_wake_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && wake_q && frame_i.addr) |=> (!wake_q && addr_q));
    // R3: in normal reception the status bit follows the received tag
    assert_tag_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && !wake_q) |=> (addr_q == $past(frame_i.addr)));
    // R7: overrun keeps the earlier byte
    assert_overrun_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_i && !(wake_q && !frame_i.addr) && flags_q.full
         && !flags_q.frame_err && !flags_q.overrun)
        |=> (flags_q.overrun && $stable(data_q)));
    // R8: a pending error flag blocks every load
    assert_error_block_R8: assert property (@(posedge clk) disable iff (rst)
        (flags_q.frame_err || flags_q.overrun) |=> $stable(data_q));
endmodule

// File: rtl/mp_wake_rx.sv
`timescale 1ns/1ps
module mp_wake_rx
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              wake_wr_i,
    input  logic              wake_wdata_i,
    input  logic              clr_full_i,
    input  logic              clr_ferr_i,
    input  logic              clr_ovr_i,
    input  logic              rx_irq_en_i,
    input  logic              err_irq_en_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              ferr_o,
    output logic              ovr_o,
    output logic              addr_flag_o,
    output logic              wake_en_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    logic      rx_s;
    logic      frame_vld;
    rx_frame_t frame;
    rx_flags_t flags;

    mpr_sync i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    mpr_sampler i_sampler (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (os_tick_i),
        .rx_i        (rx_s),
        .frame_vld_o (frame_vld),
        .frame_o     (frame)
    );

    mpr_status i_status (
        .clk          (clk),
        .rst          (rst),
        .frame_vld_i  (frame_vld),
        .frame_i      (frame),
        .wake_wr_i    (wake_wr_i),
        .wake_wdata_i (wake_wdata_i),
        .clr_full_i   (clr_full_i),
        .clr_ferr_i   (clr_ferr_i),
        .clr_ovr_i    (clr_ovr_i),
        .data_o       (rx_data_o),
        .flags_o      (flags),
        .addr_o       (addr_flag_o),
        .wake_o       (wake_en_o)
    );

    assign rx_full_o = flags.full;
    assign ferr_o    = flags.frame_err;
    assign ovr_o     = flags.overrun;
    assign rx_irq_o  = flags.full && rx_irq_en_i;
    assign err_irq_o = (flags.frame_err || flags.overrun) && err_irq_en_i;
endmodule

// File: tb/test_mp_wake_rx.sv
`timescale 1ns/1ps
module test_mp_wake_rx;
    localparam int BIT_CYC = 32;   // 16 ticks, one tick every 2 cycles
    localparam int NVEC    = 9;

    // {set_wake, data[8], tag, stop, exp_data[8], exp_full, exp_tag, exp_wake, exp_ferr}
    localparam logic [22:0] VECS [0:NVEC-1] = '{
        {1'b1, 8'h11, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'h22, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'h5A, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h33, 1'b0, 1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h44, 1'b0, 1'b1, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'h66, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'hA7, 1'b1, 1'b1, 8'hA7, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h0F, 1'b0, 1'b0, 8'hA7, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'hC3, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick_div = 1'b0;
    logic       tick_gate = 1'b1;
    logic       wake_wr = 1'b0, wake_wdata = 1'b0;
    logic       clr_full = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0;
    logic       rx_irq_en = 1'b1, err_irq_en = 1'b1;
    logic [7:0] rx_data;
    logic       rx_full, ferr, ovr, addr_flag, wake_en, rx_irq, err_irq;
    logic [22:0] cur;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;
    always_ff @(posedge clk) tick_div <= ~tick_div;

    mp_wake_rx i_mp_wake_rx (
        .clk (clk), .rst (rst), .rx_i (rx), .os_tick_i (tick_div & tick_gate),
        .wake_wr_i (wake_wr), .wake_wdata_i (wake_wdata),
        .clr_full_i (clr_full), .clr_ferr_i (clr_ferr), .clr_ovr_i (clr_ovr),
        .rx_irq_en_i (rx_irq_en), .err_irq_en_i (err_irq_en),
        .rx_data_o (rx_data), .rx_full_o (rx_full), .ferr_o (ferr), .ovr_o (ovr),
        .addr_flag_o (addr_flag), .wake_en_o (wake_en),
        .rx_irq_o (rx_irq), .err_irq_o (err_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic tag, input logic stop);
        logic [10:0] bits;
        bits = {stop, tag, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            @(negedge clk) rx = bits[b];
            repeat (BIT_CYC - 1) @(negedge clk);
        end
        @(negedge clk) rx = 1'b1;
        repeat (BIT_CYC + 16) @(negedge clk);
    endtask

    task automatic clear_flags(input logic f, input logic e, input logic o);
        @(negedge clk) begin clr_full = f; clr_ferr = e; clr_ovr = o; end
        @(negedge clk) begin clr_full = 1'b0; clr_ferr = 1'b0; clr_ovr = 1'b0; end
    endtask

    task automatic write_wake(input logic v);
        @(negedge clk) begin wake_wr = 1'b1; wake_wdata = v; end
        @(negedge clk) wake_wr = 1'b0;
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 data", rx_data, 0);
        check("R1 flags", {rx_full, ferr, ovr}, 0);
        check("R1 tag/wake", {addr_flag, wake_en}, 0);
        check("R1 irqs", {rx_irq, err_irq}, 0);

        // Table: mixed stream with wake-up armed (R3 R4 R5 R6 R12)
        for (int i = 0; i < NVEC; i++) begin
            cur = VECS[i];
            if (cur[22]) write_wake(1'b1);
            send_frame(cur[21:14], cur[13], cur[12]);
            check($sformatf("R4/R5 data v%0d", i), rx_data, cur[11:4]);
            check($sformatf("R3 full v%0d", i), rx_full, cur[3]);
            check($sformatf("R3 tag v%0d", i), addr_flag, cur[2]);
            check($sformatf("R5 wake v%0d", i), wake_en, cur[1]);
            check($sformatf("R6 ferr v%0d", i), ferr, cur[0]);
            clear_flags(1'b1, 1'b1, 1'b1);
            check($sformatf("R9 cleared v%0d", i), {rx_full, ferr, ovr}, 0);
        end

        // R7 overrun and R10 interrupts
        send_frame(8'h81, 1'b0, 1'b1);
        check("R10 rx_irq", rx_irq, 1);
        check("R10 err_irq idle", err_irq, 0);
        send_frame(8'h7E, 1'b0, 1'b1);
        check("R7 ovr", ovr, 1);
        check("R7 data kept", rx_data, 8'h81);
        check("R10 err_irq", err_irq, 1);
        @(negedge clk) begin rx_irq_en = 1'b0; err_irq_en = 1'b0; end
        @(negedge clk);
        check("R10 irqs masked", {rx_irq, err_irq}, 0);
        @(negedge clk) begin rx_irq_en = 1'b1; err_irq_en = 1'b1; end

        // R8 error flag blocks loads
        clear_flags(1'b1, 1'b0, 1'b0);
        send_frame(8'h55, 1'b0, 1'b1);
        check("R8 blocked data", rx_data, 8'h81);
        check("R8 blocked full", rx_full, 0);
        clear_flags(1'b0, 1'b0, 1'b1);
        check("R9 ovr cleared", ovr, 0);
        send_frame(8'h55, 1'b0, 1'b1);
        check("R8 unblocked data", rx_data, 8'h55);
        clear_flags(1'b1, 1'b1, 1'b1);

        // R2 short low glitch
        @(negedge clk) rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (12 * BIT_CYC) @(negedge clk);
        check("R2 glitch flags", {rx_full, ferr, ovr}, 0);
        check("R2 glitch data", rx_data, 8'h55);

        // R11 oversampling enable held low
        @(negedge clk) tick_gate = 1'b0;
        send_frame(8'h99, 1'b0, 1'b1);
        @(negedge clk) tick_gate = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        check("R11 gated no frame", {rx_full, ferr, ovr}, 0);
        send_frame(8'h99, 1'b0, 1'b1);
        check("R11 ungated data", rx_data, 8'h99);
        clear_flags(1'b1, 1'b1, 1'b1);

        // R12 software arm and disarm
        write_wake(1'b1);
        check("R12 armed", wake_en, 1);
        write_wake(1'b0);
        check("R12 disarmed", wake_en, 0);
        send_frame(8'h12, 1'b0, 1'b1);
        check("R12 data after disarm", rx_data, 8'h12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end
endmodule